// File: doc/BRIEF.md
# DRAM Refresh Rate Controller

This block keeps the refresh control word of a DDR2-class memory controller and decides when the command sequencer has to refresh the attached memory. A down-counter measures the programmed refresh interval in controller clocks. Each time it runs out, one auto-refresh is owed to the sequencer, which takes it over a valid/ready handshake. A single control bit moves the memory into self-refresh or brings it back out. That move is requested from the sequencer as a level and confirmed by an acknowledge. The block drives no memory pins and does no command sequencing of its own.

Software writes the whole 32-bit word in one cycle. The write has no address. The word can be read back at any time. An interval below 256 clocks is not stored as written. The block stores twice the row-refresh-cycle time, taken from the `trfc` input in the write cycle. Refreshes that the sequencer cannot take at once are counted, up to eight, so that a busy sequencer loses none of them.

Refresh back-pressure: once `ref_valid` is high it stays high until a cycle with `ref_ready` high. One refresh is handed over in each cycle where both are high. Holding `ref_ready` low only delays refreshes, until eight are owed. From then on, further expiries are dropped.

Top module: `refresh_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00000753, `sr_active` is 0, and `ref_valid` and `sr_req` are low.
- R2: A cycle with `cfg_we` high stores `cfg_wdata[31]` as the self-refresh bit and `cfg_wdata[15:0]` as the interval. From the next cycle, `cfg_rdata` shows the bit in position 31 and the interval in bits 15:0.
- R3: Bits 30:16 of `cfg_rdata` always read 0, whatever was written to them.
- R4: If the written interval is below 0x0100, the stored interval is 2 × `trfc`, with `trfc` sampled in the write cycle. A written interval of exactly 0x0100 is stored unchanged.
- R5: While self-refresh is neither requested nor active, one refresh becomes owed every N cycles, where N is the stored interval. After reset, or after a write, the first refresh is owed at the N-th rising edge.
- R6: `ref_valid` is high while at least one refresh is owed. Each cycle with `ref_valid` and `ref_ready` both high hands over one refresh. At most 8 refreshes are owed; further expiries are dropped.
- R7: `sr_req` is high while the self-refresh bit differs from `sr_active`. An entry request is held back until no refresh is owed.
- R8: `sr_active` takes the value of the self-refresh bit only on a cycle with `sr_req` and `sr_ack` both high. Otherwise it holds its value.
- R9: While the self-refresh bit is 1 or `sr_active` is 1, the interval counter does not run. While `sr_active` is 1, `ref_valid` stays low.
- R10: On the acknowledged exit from self-refresh, the counter restarts. The next refresh is owed N cycles after that acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Stored control word |
| trfc | input | 8 | Row-refresh-cycle time from the timing register |
| ref_valid | output | 1 | At least one auto-refresh is owed |
| ref_ready | input | 1 | Sequencer takes one auto-refresh |
| sr_req | output | 1 | Self-refresh entry or exit wanted |
| sr_ack | input | 1 | Sequencer has completed the self-refresh change |
| sr_active | output | 1 | Memory is in self-refresh |

## Verification
A wrong interval count shows up at `ref_valid` as a refresh that comes one or more cycles early or late. This appears within one interval of the fault: at most 65,535 cycles, and a few hundred with the intervals the bench uses. A corrupted owed-refresh count shows up as a different number of handshakes when a stalled sequencer drains. A bad self-refresh state shows up at once as `sr_req` or `sr_active` disagreeing with the stored bit. The bench compares every output against its own cycle model on every cycle, so each of these is caught in the cycle where it first reaches a port.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned SR_POS = 31;

  typedef enum logic [1:0] {
    PEND_KEEP = 2'd0,
    PEND_UP   = 2'd1,
    PEND_DOWN = 2'd2
  } pend_op_e;
endpackage

// File: rtl/refresh_cfg_reg.sv
module refresh_cfg_reg
  import refresh_pkg::*;
#(
  parameter int unsigned IVL_W  = 16,
  parameter int unsigned TRFC_W = 8,
  parameter logic [IVL_W-1:0] RESET_IVL = 16'h0753,
  parameter logic [IVL_W-1:0] IVL_FLOOR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [TRFC_W-1:0] trfc,
  output logic              sr_bit,
  output logic [IVL_W-1:0]  ivl,
  output logic [IVL_W-1:0]  ivl_wr_val,
  output logic [CFG_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = CFG_W - 1 - IVL_W;

  logic [IVL_W-1:0] wr_ivl;

  // Intervals under the floor are replaced by twice the row-cycle time.
  always_comb begin
    wr_ivl     = wr_data[IVL_W-1:0];
    ivl_wr_val = (wr_ivl < IVL_FLOOR) ? IVL_W'({trfc, 1'b0}) : wr_ivl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_bit <= 1'b0;
      ivl    <= RESET_IVL;
    end else if (wr_en) begin
      sr_bit <= wr_data[SR_POS];
      ivl    <= ivl_wr_val;
    end
  end

  assign rd_data = {sr_bit, {PAD_W{1'b0}}, ivl};
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_pkg::*;
#(
  parameter int unsigned IVL_W    = 16,
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4,
  parameter logic [IVL_W-1:0] RESET_IVL = 16'h0753
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IVL_W-1:0]  load_val,
  input  logic              restart,
  input  logic [IVL_W-1:0]  ivl,
  input  logic              freeze,
  input  logic              take,
  output logic [PEND_W-1:0] pend,
  output logic              pend_zero
);
  logic [IVL_W-1:0] cnt_q;
  logic             expire;
  pend_op_e         op;

  assign expire = !freeze && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= RESET_IVL - 1'b1;
    else if (load)    cnt_q <= load_val - 1'b1;
    else if (restart) cnt_q <= ivl - 1'b1;
    else if (freeze)  cnt_q <= cnt_q;
    else if (expire)  cnt_q <= ivl - 1'b1;
    else              cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    unique case ({expire, take})
      2'b10:   op = PEND_UP;
      2'b01:   op = PEND_DOWN;
      default: op = PEND_KEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      unique case (op)
        PEND_UP:   if (pend != PEND_W'(PEND_MAX)) pend <= pend + 1'b1;
        PEND_DOWN: pend <= pend - 1'b1;
        default:   pend <= pend;
      endcase
    end
  end

  assign pend_zero = (pend == '0);
endmodule

// File: rtl/refresh_sr_ctl.sv
module refresh_sr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_bit,
  input  logic pend_zero,
  input  logic sr_ack,
  output logic sr_req,
  output logic sr_active,
  output logic freeze,
  output logic exit_done
);
  logic want_in, want_out, hs;

  always_comb begin
    want_in   = sr_bit && !sr_active && pend_zero;
    want_out  = !sr_bit && sr_active;
    sr_req    = want_in || want_out;
    hs        = sr_req && sr_ack;
    exit_done = hs && sr_active;
    freeze    = sr_bit || sr_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_active <= 1'b0;
    else if (hs) sr_active <= sr_bit;
  end
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int unsigned IVL_W    = 16,
  parameter int unsigned TRFC_W   = 8,
  parameter int unsigned PEND_MAX = 8,
  parameter logic [IVL_W-1:0] RESET_IVL = 16'h0753,
  parameter logic [IVL_W-1:0] IVL_FLOOR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [TRFC_W-1:0] trfc,
  output logic              ref_valid,
  input  logic              ref_ready,
  output logic              sr_req,
  input  logic              sr_ack,
  output logic              sr_active
);
  localparam int unsigned PEND_W = $clog2(PEND_MAX + 1);

  logic              sr_bit, freeze, exit_done, pend_zero, take;
  logic [IVL_W-1:0]  ivl, ivl_wr_val;
  logic [PEND_W-1:0] pend_q;

  refresh_cfg_reg #(
    .IVL_W(IVL_W), .TRFC_W(TRFC_W), .RESET_IVL(RESET_IVL), .IVL_FLOOR(IVL_FLOOR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata), .trfc(trfc),
    .sr_bit(sr_bit), .ivl(ivl), .ivl_wr_val(ivl_wr_val), .rd_data(cfg_rdata)
  );

  refresh_timer #(
    .IVL_W(IVL_W), .PEND_MAX(PEND_MAX), .PEND_W(PEND_W), .RESET_IVL(RESET_IVL)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .load_val(ivl_wr_val),
    .restart(exit_done), .ivl(ivl), .freeze(freeze), .take(take),
    .pend(pend_q), .pend_zero(pend_zero)
  );

  refresh_sr_ctl u_sr (
    .clk(clk), .rst_n(rst_n), .sr_bit(sr_bit), .pend_zero(pend_zero),
    .sr_ack(sr_ack), .sr_req(sr_req), .sr_active(sr_active),
    .freeze(freeze), .exit_done(exit_done)
  );

  assign ref_valid = !pend_zero && !sr_active;
  assign take      = ref_valid && ref_ready;
endmodule

// File: rtl/refresh_ctrl_chk.sv
module refresh_ctrl_chk #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              ref_valid,
  input logic              ref_ready,
  input logic              sr_req,
  input logic              sr_ack,
  input logic              sr_active,
  input logic [PEND_W-1:0] pend_q
);
  // R6: an offered refresh is not withdrawn before it is taken
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid);

  // R6: owed-refresh count never exceeds its ceiling
  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_W'(PEND_MAX));

  // R8: self-refresh status changes only on a handshake
  a_r8_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_req && sr_ack) |=> $stable(sr_active));

  // R9: no auto-refresh offered during self-refresh
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_valid);

  // R7: entry is requested only once every owed refresh has gone
  a_r7_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    sr_req && !sr_active |-> !ref_valid);

  // R2: written self-refresh bit reads back next cycle
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[31] == $past(cfg_wdata[31]));
endmodule

bind refresh_ctrl refresh_ctrl_chk #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .sr_req(sr_req), .sr_ack(sr_ack), .sr_active(sr_active), .pend_q(pend_q)
);

// File: tb/refresh_ctrl_bench.sv
module refresh_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n, cfg_we, ref_ready, sr_ack;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [7:0]  trfc;
  logic        ref_valid, sr_req, sr_active;

  always #5 clk = ~clk;

  refresh_ctrl u_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trfc(trfc), .ref_valid(ref_valid),
    .ref_ready(ref_ready), .sr_req(sr_req), .sr_ack(sr_ack), .sr_active(sr_active)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit chk_en = 1'b0, done = 1'b0;

  // Reference model built from the requirements
  logic        m_sr, m_act;
  logic [15:0] m_ivl, m_cnt;
  int          m_pend;

  function automatic logic [15:0] stored_ivl(logic [31:0] w, logic [7:0] t);
    return (w[15:0] < 16'h0100) ? {7'd0, t, 1'b0} : w[15:0];
  endfunction
  function automatic logic exp_valid();
    return (m_pend != 0) && !m_act;
  endfunction
  function automatic logic exp_sr_req();
    return (m_sr && !m_act && m_pend == 0) || (!m_sr && m_act);
  endfunction
  function automatic logic [31:0] exp_rdata();
    return {m_sr, 15'd0, m_ivl};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin : model
    logic frz, tick, hs, srhs;
    cyc++;
    if (!rst_n) begin
      m_sr = 1'b0; m_act = 1'b0; m_ivl = 16'h0753; m_cnt = 16'h0752; m_pend = 0;
    end else begin
      frz  = m_sr || m_act;
      tick = !frz && (m_cnt == 16'd0);
      hs   = exp_valid() && ref_ready;
      srhs = exp_sr_req() && sr_ack;
      if (tick && !hs && m_pend < 8) m_pend++;
      else if (hs && !tick)          m_pend--;
      if (cfg_we)           m_cnt = stored_ivl(cfg_wdata, trfc) - 16'd1;
      else if (srhs && m_act) m_cnt = m_ivl - 16'd1;
      else if (frz)         m_cnt = m_cnt;
      else if (tick)        m_cnt = m_ivl - 16'd1;
      else                  m_cnt = m_cnt - 16'd1;
      if (srhs) m_act = m_sr;
      if (cfg_we) begin
        m_sr  = cfg_wdata[31];
        m_ivl = stored_ivl(cfg_wdata, trfc);
      end
    end
    if (cyc == 190000 && !done) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // Per-cycle comparison; all outputs depend on state only
  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      check("R2 rdata", cfg_rdata, exp_rdata());
      check("R6 ref_valid", {31'd0, ref_valid}, {31'd0, exp_valid()});
      check("R7 sr_req", {31'd0, sr_req}, {31'd0, exp_sr_req()});
      check("R8 sr_active", {31'd0, sr_active}, {31'd0, m_act});
    end
  end

  task automatic wr(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Cycles from the current negedge until ref_valid, minus one
  task automatic measure(output int n);
    n = 1;
    while (!ref_valid) begin @(negedge clk); n++; end
    n = n - 1;
  endtask

  initial begin
    int n, k;
    bit seen;
    void'($urandom(32'd7351));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; trfc = 8'h30;
    ref_ready = 1'b0; sr_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", cfg_rdata, 32'h0000_0753);
    check("R1 reset outputs", {29'd0, ref_valid, sr_req, sr_active}, 32'd0);
    rst_n = 1'b1; chk_en = 1'b1;

    // R5: first refresh after reset at edge 0x753
    n = 0;
    while (!ref_valid) begin @(negedge clk); n++; end
    check("R5 reset period", n, 32'h753);
    ref_ready = 1'b1; @(negedge clk); ref_ready = 1'b0;

    // R4 and R3: floored write, reserved bits set
    wr(32'h7FFF_00FF);
    check("R3 reserved zero", cfg_rdata, 32'h0000_0060);
    measure(n);
    check("R4 floored period", n, 32'h60);
    ref_ready = 1'b1; @(negedge clk); ref_ready = 1'b0;

    // R4 boundary: exactly the floor is kept
    wr(32'h0000_0100);
    check("R4 floor kept", cfg_rdata, 32'h0000_0100);
    measure(n);
    check("R5 written period", n, 32'h100);

    // R6: stall long enough to saturate, then drain
    repeat (2400) @(negedge clk);
    ref_ready = 1'b1; k = 0;
    while (ref_valid) begin @(negedge clk); k++; end
    ref_ready = 1'b0;
    check("R6 saturated drain", k, 32'd8);

    // R7: entry waits for owed refreshes
    repeat (520) @(negedge clk);
    sr_ack = 1'b1;
    wr(32'h8000_0100);
    seen = 1'b0;
    repeat (20) begin seen |= sr_req; @(negedge clk); end
    check("R7 entry held", {31'd0, seen}, 32'd0);
    check("R7 refresh owed", {31'd0, ref_valid}, 32'd1);
    ref_ready = 1'b1;
    while (ref_valid) @(negedge clk);
    ref_ready = 1'b0;
    check("R7 entry raised", {30'd0, sr_req, sr_active}, 32'd2);
    @(negedge clk);
    check("R8 entered", {30'd0, sr_req, sr_active}, 32'd1);

    // R9: quiet during self-refresh
    seen = 1'b0;
    repeat (600) begin seen |= ref_valid; @(negedge clk); end
    check("R9 no refresh", {31'd0, seen}, 32'd0);

    // R10: exit waits for ack, counter restarts at ack
    sr_ack = 1'b0;
    wr(32'h0000_0120);
    repeat (50) @(negedge clk);
    check("R8 exit pending", {30'd0, sr_req, sr_active}, 32'd3);
    sr_ack = 1'b1; @(negedge clk); sr_ack = 1'b0;
    check("R10 exited", {31'd0, sr_active}, 32'd0);
    measure(n);
    check("R10 restart period", n, 32'h120);

    // Random phase
    for (int i = 0; i < 40000; i++) begin
      ref_ready = ($urandom_range(0, 3) != 0);
      sr_ack    = ($urandom_range(0, 4) == 0);
      trfc      = 8'($urandom_range(1, 127));
      if ($urandom_range(0, 599) == 0) begin
        cfg_we = 1'b1;
        cfg_wdata[31]    = ($urandom_range(0, 3) == 0);
        cfg_wdata[30:16] = 15'($urandom_range(0, 32767));
        cfg_wdata[15:0]  = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 255))
                                                       : 16'($urandom_range(256, 700));
      end else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule